// File: doc/BRIEF.md
# Tag-Based Reservation Station Pool

This block is a small pool of waiting slots for one class of functional unit in an out-of-order core. An instruction enters a free slot at issue, carrying for each of its two source operands either a value that is already known or the tag of the slot that will produce it. The slot then watches a single shared result bus. Whenever the bus carries a tag that a waiting operand names, the slot copies the bus data into that operand and marks it present.

Once both operands are present, the slot asks the execution unit to take it. The lowest-numbered ready slot wins, and at most one slot is handed over per cycle, only when the unit says it can accept. A slot that has been handed over stays occupied but is not offered again. It becomes free on the cycle after its own tag appears on the result bus. Instructions enter in order, but they leave for execution and complete in whatever order their operands arrive.

Tags name slots as index plus one. The value 0 means "operand already present". With the default of three slots, tags are two bits wide.

Top module: `rsv_pool`

## Requirements
- R1: `issueReady` is high exactly when at least one slot is free. An issue request made while all slots are occupied is ignored: no slot changes and no later dispatch results from it.
- R2: `issueTag` gives the tag the next accepted issue will receive. It is the lowest free slot index plus one, so tags run 1..3 and 0 never names a slot.
- R3: A source issued with tag 0 takes its value from the issue data input, and that operand counts as present from the next cycle.
- R4: A source issued with a nonzero tag waits. The first result-bus transfer (`bcastValid` high) whose tag equals it loads `bcastData` into that operand. This works independently for operand A and operand B and in every slot at once.
- R5: If the result bus carries a source's producer tag in the very cycle that source is issued, the bus data is captured at issue and the wakeup is not lost.
- R6: `dispValid` is high only while some occupied slot has both operands present and has not yet been handed over. `dispTag`, `dispOpA` and `dispOpB` then describe the lowest-indexed such slot, and they hold until `dispReady` is high.
- R7: A slot accepted by the execution unit (`dispValid` and `dispReady` both high) is not offered again while it waits for its result.
- R8: A result-bus transfer carrying a slot's own tag frees that slot, and the slot can be issued into again from the next cycle.
- R9: After reset all slots are free: `issueReady` is 1, `issueTag` is 1 and `dispValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueTagA | input | 2 | Producer tag of operand A, 0 = value supplied |
| issueDataA | input | 16 | Value of operand A when its tag is 0 |
| issueTagB | input | 2 | Producer tag of operand B, 0 = value supplied |
| issueDataB | input | 16 | Value of operand B when its tag is 0 |
| issueReady | output | 1 | A slot is free, so an issue is accepted this cycle |
| issueTag | output | 2 | Tag the accepted issue is given |
| bcastValid | input | 1 | Result bus carries a result this cycle |
| bcastTag | input | 2 | Tag of the slot whose result is on the bus |
| bcastData | input | 16 | Result value |
| dispValid | output | 1 | A slot is offered to the execution unit |
| dispReady | input | 1 | Execution unit accepts the offered slot |
| dispTag | output | 2 | Tag of the offered slot |
| dispOpA | output | 16 | Operand A of the offered slot |
| dispOpB | output | 16 | Operand B of the offered slot |

## Verification
Every piece of internal state reaches the ports within a few cycles. A lost or wrong tag match leaves a slot that never raises `dispValid`, or that offers a stale operand on `dispOpA`/`dispOpB` on the first cycle it becomes ready. An occupancy bit stuck high or low shows on the next cycle as a wrong `issueReady` or `issueTag`. A missing handed-over mark shows as the same `dispTag` offered again one cycle after acceptance. The stimulus therefore follows every wakeup with a dispatch and every completion with a fresh issue, so each fault surfaces at most two cycles after it occurs.

// File: rtl/rsv_pool_pkg.sv
package rsv_pool_pkg;
  localparam int unsigned NUM_ENTRIES = 3;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned TAG_W       = $clog2(NUM_ENTRIES + 1);
  localparam int unsigned IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [NUM_ENTRIES-1:0] loadA;
    logic [NUM_ENTRIES-1:0] loadB;
    logic [NUM_ENTRIES-1:0] busA;   // 1: load from result bus, 0: from issue data
    logic [NUM_ENTRIES-1:0] busB;
    logic [IDX_W-1:0]       dispIdx;
  } rsStrobe_t;
endpackage

// File: rtl/rsv_pool_ctrl.sv
module rsv_pool_ctrl
  import rsv_pool_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   issueValid,
  input  logic [TAG_W-1:0]       issueTagA,
  input  logic [TAG_W-1:0]       issueTagB,
  input  logic                   bcastValid,
  input  logic [TAG_W-1:0]       bcastTag,
  input  logic                   dispReady,
  output logic                   issueReady,
  output logic [TAG_W-1:0]       issueTag,
  output logic                   dispValid,
  output logic [TAG_W-1:0]       dispTag,
  output logic [NUM_ENTRIES-1:0] busyVec,
  output rsStrobe_t              strobe
);
  logic [NUM_ENTRIES-1:0] readyVec;
  logic [NUM_ENTRIES-1:0] loadA, loadB, busA, busB;
  logic [IDX_W-1:0]       freeIdx, dispIdx;
  logic                   anyFree, issueFire, dispFire;
  logic                   hitIssueA, hitIssueB;

  // Lowest free slot and lowest ready slot.
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    dispIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!busyVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
      if (readyVec[i]) dispIdx = IDX_W'(i);
    end
  end

  assign issueReady = anyFree;
  assign issueTag   = TAG_W'(freeIdx) + 1'b1;
  assign issueFire  = issueValid && anyFree;
  assign dispValid  = |readyVec;
  assign dispTag    = TAG_W'(dispIdx) + 1'b1;
  assign dispFire   = dispValid && dispReady;
  assign hitIssueA  = bcastValid && (bcastTag == issueTagA);
  assign hitIssueB  = bcastValid && (bcastTag == issueTagB);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gSlot
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(g + 1);
    logic             busy, sent;
    logic [TAG_W-1:0] qA, qB;
    logic             alloc, wakeA, wakeB, selfDone;

    assign alloc    = issueFire && (freeIdx == IDX_W'(g));
    assign wakeA    = busy && (qA != '0) && bcastValid && (bcastTag == qA);
    assign wakeB    = busy && (qB != '0) && bcastValid && (bcastTag == qB);
    assign selfDone = busy && bcastValid && (bcastTag == MY_TAG);

    assign loadA[g] = alloc ? ((issueTagA == '0) || hitIssueA) : wakeA;
    assign loadB[g] = alloc ? ((issueTagB == '0) || hitIssueB) : wakeB;
    assign busA[g]  = alloc ? (issueTagA != '0) : 1'b1;
    assign busB[g]  = alloc ? (issueTagB != '0) : 1'b1;

    assign busyVec[g]  = busy;
    assign readyVec[g] = busy && !sent && (qA == '0) && (qB == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy <= 1'b0;
        sent <= 1'b0;
        qA   <= '0;
        qB   <= '0;
      end else if (alloc) begin
        busy <= 1'b1;
        sent <= 1'b0;
        qA   <= (issueTagA != '0 && !hitIssueA) ? issueTagA : '0;
        qB   <= (issueTagB != '0 && !hitIssueB) ? issueTagB : '0;
      end else if (busy) begin
        if (wakeA) qA <= '0;
        if (wakeB) qB <= '0;
        if (dispFire && dispIdx == IDX_W'(g)) sent <= 1'b1;
        if (selfDone) begin
          busy <= 1'b0;
          sent <= 1'b0;
        end
      end
    end
  end

  assign strobe = '{loadA: loadA, loadB: loadB, busA: busA, busB: busB, dispIdx: dispIdx};
endmodule

// File: rtl/rsv_pool_dpath.sv
module rsv_pool_dpath
  import rsv_pool_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strobe,
  input  logic [DATA_W-1:0] issueDataA,
  input  logic [DATA_W-1:0] issueDataB,
  input  logic [DATA_W-1:0] bcastData,
  output logic [DATA_W-1:0] dispOpA,
  output logic [DATA_W-1:0] dispOpB
);
  logic [DATA_W-1:0] valA [NUM_ENTRIES];
  logic [DATA_W-1:0] valB [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gVal
    always_ff @(posedge clk) begin
      if (!rstN) begin
        valA[g] <= '0;
        valB[g] <= '0;
      end else begin
        if (strobe.loadA[g]) valA[g] <= strobe.busA[g] ? bcastData : issueDataA;
        if (strobe.loadB[g]) valB[g] <= strobe.busB[g] ? bcastData : issueDataB;
      end
    end
  end

  always_comb begin
    dispOpA = '0;
    dispOpB = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (strobe.dispIdx == IDX_W'(i)) begin
        dispOpA = valA[i];
        dispOpB = valB[i];
      end
    end
  end
endmodule

// File: rtl/rsv_pool.sv
module rsv_pool
  import rsv_pool_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [TAG_W-1:0]  issueTagA,
  input  logic [DATA_W-1:0] issueDataA,
  input  logic [TAG_W-1:0]  issueTagB,
  input  logic [DATA_W-1:0] issueDataB,
  output logic              issueReady,
  output logic [TAG_W-1:0]  issueTag,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  output logic              dispValid,
  input  logic              dispReady,
  output logic [TAG_W-1:0]  dispTag,
  output logic [DATA_W-1:0] dispOpA,
  output logic [DATA_W-1:0] dispOpB
);
  rsStrobe_t              strobe;
  logic [NUM_ENTRIES-1:0] busyVec;

  rsv_pool_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueTagA(issueTagA), .issueTagB(issueTagB),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .dispReady(dispReady),
    .issueReady(issueReady), .issueTag(issueTag),
    .dispValid(dispValid), .dispTag(dispTag),
    .busyVec(busyVec), .strobe(strobe)
  );

  rsv_pool_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueDataA(issueDataA), .issueDataB(issueDataB), .bcastData(bcastData),
    .dispOpA(dispOpA), .dispOpB(dispOpB)
  );
endmodule

// File: rtl/rsv_pool_chk.sv
module rsv_pool_chk
  import rsv_pool_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   issueValid,
  input logic                   issueReady,
  input logic                   bcastValid,
  input logic [TAG_W-1:0]       bcastTag,
  input logic                   dispValid,
  input logic                   dispReady,
  input logic [TAG_W-1:0]       dispTag,
  input logic [NUM_ENTRIES-1:0] busyVec
);
  // Accepted issue with no completion adds exactly one occupied slot.
  assert_issue_fills_R1: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueReady && !bcastValid |=> $countones(busyVec) == $past($countones(busyVec)) + 1);

  // Full pool with no completion stays closed to issue.
  assert_full_stalls_R1: assert property (@(posedge clk) disable iff (!rstN)
    (&busyVec) && !bcastValid |=> !issueReady);

  // Offered slot is a valid, occupied slot.
  assert_disp_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (dispTag != '0) && (dispTag <= TAG_W'(NUM_ENTRIES)) && busyVec[dispTag - 1'b1]);

  // An accepted slot is not offered on the following cycle.
  assert_no_reoffer_R7: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady |=> !(dispValid && dispTag == $past(dispTag)));

  // Own-tag completion leaves the slot free.
  assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid && bcastTag != '0 && bcastTag <= TAG_W'(NUM_ENTRIES)
      |=> !busyVec[$past(bcastTag) - 1'b1]);
endmodule

bind rsv_pool rsv_pool_chk uChk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .bcastValid(bcastValid), .bcastTag(bcastTag), .dispValid(dispValid),
  .dispReady(dispReady), .dispTag(dispTag), .busyVec(busyVec)
);

// File: tb/rsv_pool_test.sv
module rsv_pool_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueTagA = '0, issueTagB = '0;
  logic [15:0] issueDataA = '0, issueDataB = '0;
  logic        issueReady;
  logic [1:0]  issueTag;
  logic        bcastValid = 1'b0;
  logic [1:0]  bcastTag = '0;
  logic [15:0] bcastData = '0;
  logic        dispValid;
  logic        dispReady = 1'b0;
  logic [1:0]  dispTag;
  logic [15:0] dispOpA, dispOpB;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  rsv_pool uut (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        iv;
    logic [1:0]  aT;
    logic [15:0] aD;
    logic [1:0]  bT;
    logic [15:0] bD;
    logic        bv;
    logic [1:0]  bcT;
    logic [15:0] bcD;
    logic        dr;
    logic        eIr;
    logic [1:0]  eIt;
    logic        eDv;
    logic [1:0]  eDt;
    logic [15:0] eA;
    logic [15:0] eB;
  } vec_t;

  // Each row: inputs driven at a falling edge; expected outputs sampled
  // before the next rising edge (they reflect state from earlier edges).
  localparam vec_t VEC [13] = '{
    '{1'b1,2'd0,16'h0011,2'd0,16'h0022, 1'b0,2'd0,16'h0000, 1'b0, 1'b1,2'd1, 1'b0,2'd0,16'h0000,16'h0000},
    '{1'b1,2'd1,16'h0000,2'd0,16'h0033, 1'b0,2'd0,16'h0000, 1'b1, 1'b1,2'd2, 1'b1,2'd1,16'h0011,16'h0022},
    '{1'b1,2'd0,16'h0044,2'd2,16'h0000, 1'b0,2'd0,16'h0000, 1'b1, 1'b1,2'd3, 1'b0,2'd0,16'h0000,16'h0000},
    '{1'b1,2'd0,16'h0099,2'd0,16'h0099, 1'b1,2'd1,16'h0055, 1'b1, 1'b0,2'd0, 1'b0,2'd0,16'h0000,16'h0000},
    '{1'b0,2'd0,16'h0000,2'd0,16'h0000, 1'b0,2'd0,16'h0000, 1'b0, 1'b1,2'd1, 1'b1,2'd2,16'h0055,16'h0033},
    '{1'b1,2'd2,16'h0000,2'd3,16'h0000, 1'b0,2'd0,16'h0000, 1'b1, 1'b1,2'd1, 1'b1,2'd2,16'h0055,16'h0033},
    '{1'b0,2'd0,16'h0000,2'd0,16'h0000, 1'b1,2'd2,16'h0066, 1'b1, 1'b0,2'd0, 1'b0,2'd0,16'h0000,16'h0000},
    '{1'b0,2'd0,16'h0000,2'd0,16'h0000, 1'b0,2'd0,16'h0000, 1'b1, 1'b1,2'd2, 1'b1,2'd3,16'h0044,16'h0066},
    '{1'b0,2'd0,16'h0000,2'd0,16'h0000, 1'b1,2'd3,16'h0077, 1'b1, 1'b1,2'd2, 1'b0,2'd0,16'h0000,16'h0000},
    '{1'b0,2'd0,16'h0000,2'd0,16'h0000, 1'b0,2'd0,16'h0000, 1'b1, 1'b1,2'd2, 1'b1,2'd1,16'h0066,16'h0077},
    '{1'b1,2'd1,16'h0000,2'd0,16'h0088, 1'b1,2'd1,16'h00AA, 1'b1, 1'b1,2'd2, 1'b0,2'd0,16'h0000,16'h0000},
    '{1'b0,2'd0,16'h0000,2'd0,16'h0000, 1'b0,2'd0,16'h0000, 1'b1, 1'b1,2'd1, 1'b1,2'd2,16'h00AA,16'h0088},
    '{1'b0,2'd0,16'h0000,2'd0,16'h0000, 1'b0,2'd0,16'h0000, 1'b1, 1'b1,2'd1, 1'b0,2'd0,16'h0000,16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic iv, input logic [1:0] aT, input logic [15:0] aD,
                       input logic [1:0] bT, input logic [15:0] bD,
                       input logic bv, input logic [1:0] bcT, input logic [15:0] bcD,
                       input logic dr);
    issueValid = iv; issueTagA = aT; issueDataA = aD; issueTagB = bT; issueDataB = bD;
    bcastValid = bv; bcastTag = bcT; bcastData = bcD; dispReady = dr;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R9 issueReady after reset", 32'(issueReady), 32'd1);
    chk("R9 issueTag after reset",   32'(issueTag),   32'd1);
    chk("R9 dispValid after reset",  32'(dispValid),  32'd0);

    // Table: fill, full stall (R1), wakeups (R4), completion frees (R8),
    // lowest free tag (R2), ready values (R3), same-cycle capture (R5),
    // single offer per acceptance (R6, R7).
    for (int r = 0; r < 13; r++) begin
      if (r > 0) @(negedge clk);
      drive(VEC[r].iv, VEC[r].aT, VEC[r].aD, VEC[r].bT, VEC[r].bD,
            VEC[r].bv, VEC[r].bcT, VEC[r].bcD, VEC[r].dr);
      #1;
      chk($sformatf("R1 issueReady row %0d", r), 32'(issueReady), 32'(VEC[r].eIr));
      if (VEC[r].eIr)
        chk($sformatf("R2 issueTag row %0d", r), 32'(issueTag), 32'(VEC[r].eIt));
      chk($sformatf("R6 dispValid row %0d", r), 32'(dispValid), 32'(VEC[r].eDv));
      if (VEC[r].eDv) begin
        chk($sformatf("R6 dispTag row %0d", r), 32'(dispTag), 32'(VEC[r].eDt));
        chk($sformatf("R4 dispOpA row %0d", r), 32'(dispOpA), 32'(VEC[r].eA));
        chk($sformatf("R4 dispOpB row %0d", r), 32'(dispOpB), 32'(VEC[r].eB));
      end
    end

    // Directed: reset mid-run clears the pool (R9).
    @(negedge clk);
    drive(1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R9 issueReady after mid reset", 32'(issueReady), 32'd1);
    chk("R9 dispValid after mid reset",  32'(dispValid),  32'd0);

    // Directed: three ready slots, lowest index offered first (R6), held while stalled.
    drive(1'b1, 2'd0, 16'h0001, 2'd0, 16'h0002, 1'b0, 2'd0, 16'h0, 1'b0);
    @(negedge clk);
    drive(1'b1, 2'd0, 16'h0003, 2'd0, 16'h0004, 1'b0, 2'd0, 16'h0, 1'b0);
    @(negedge clk);
    drive(1'b1, 2'd0, 16'h0005, 2'd0, 16'h0006, 1'b0, 2'd0, 16'h0, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b0);
    #1;
    chk("R1 pool full", 32'(issueReady), 32'd0);
    chk("R6 first offer tag", 32'(dispTag), 32'd1);
    @(negedge clk);
    #1;
    chk("R6 offer held without dispReady", 32'(dispTag), 32'd1);
    chk("R3 slot1 opA", 32'(dispOpA), 32'h0001);
    dispReady = 1'b1;
    @(negedge clk);
    #1;
    chk("R7 next offer tag", 32'(dispTag), 32'd2);
    chk("R3 slot2 opA", 32'(dispOpA), 32'h0003);
    chk("R3 slot2 opB", 32'(dispOpB), 32'h0004);
    @(negedge clk);
    #1;
    chk("R7 third offer tag", 32'(dispTag), 32'd3);
    chk("R3 slot3 opB", 32'(dispOpB), 32'h0006);
    @(negedge clk);
    #1;
    chk("R7 nothing left to offer", 32'(dispValid), 32'd0);

    // Directed: complete slot 2 only; it becomes the lowest free (R8, R2).
    drive(1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 1'b1, 2'd2, 16'h1234, 1'b1);
    @(negedge clk);
    drive(1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1);
    #1;
    chk("R8 freed slot reusable", 32'(issueReady), 32'd1);
    chk("R2 freed slot tag", 32'(issueTag), 32'd2);

    finish_run();
  end
endmodule